// File: doc/BRIEF.md
# Payload CRC-16 Generator and Checker

This block protects the payload of a long display-link packet with a 16-bit cyclic checksum. It takes one payload byte per clock. A start strobe loads the payload length and the direction, and presets the checksum register to all ones. The packet header never passes through the block. Inside each byte, bit 0 enters the checksum first. The polynomial is x^16 + x^12 + x^5 + 1, built in reflected form with the constant 8408h. No final inversion is applied.

In transmit direction, each accepted payload byte is forwarded on the output one cycle later. The block then appends the checksum, low byte first and high byte second. While it emits those two bytes it deasserts its ready output. In receive direction, the two bytes after the payload are taken as the received checksum, low byte first. A one-cycle pass or fail pulse follows them. A check-enable control, latched at the start strobe, silences both pulses. This serves senders that fill the checksum field with 0000h.

The state machine has six states. `ST_IDLE` waits for a start strobe. `ST_PAYLOAD` counts payload bytes. `ST_TX_LO` and `ST_TX_HI` emit the checksum. `ST_RX_LO` and `ST_RX_HI` collect the received checksum. It has these transitions:
- start strobe: from any state to `ST_PAYLOAD`. With length 0 it goes to `ST_TX_LO` or `ST_RX_LO` instead.
- end of payload: `ST_PAYLOAD` to `ST_TX_LO` or `ST_RX_LO`.
- tail step: `ST_TX_LO` to `ST_TX_HI`, and on a valid byte `ST_RX_LO` to `ST_RX_HI`.
- finish: `ST_TX_HI` to `ST_IDLE`, and on a valid byte `ST_RX_HI` to `ST_IDLE`.

Top module: `crc16_payload_engine`

## Requirements
- R1: After reset, `out_vld`, `crc_ok` and `crc_err` are 0 and `in_rdy` is 1.
- R2: The checksum uses polynomial x^16+x^12+x^5+1, preset FFFFh, bit 0 of each byte first, and no final inversion. For the ASCII bytes "123456789" it is 6F91h.
- R3: In transmit direction (`mode_tx`=1 at the start strobe), a payload byte accepted in the cycle with `in_vld`=1 appears on `out_data` with `out_vld`=1 in the next cycle.
- R4: In transmit direction, the two cycles after the last payload byte is output carry the checksum on `out_data` with `out_vld`=1. Bits 7:0 come first, then bits 15:8.
- R5: While the checksum bytes are being emitted, `in_rdy` is 0. Bytes offered then are ignored: they do not appear on the output and do not change the checksum.
- R6: A start strobe with `pay_len`=0 yields checksum FFFFh. In transmit direction the output is FFh, FFh.
- R7: The payload ends after `pay_len` accepted bytes, or earlier at an accepted byte with `in_last`=1.
- R8: In receive direction, when the two bytes after the payload (low, then high) equal the computed checksum and checking is enabled, `crc_ok` is 1 for exactly one cycle. That cycle immediately follows the acceptance of the high byte.
- R9: In receive direction with checking enabled, a mismatching received checksum gives a one-cycle `crc_err` pulse in the same cycle position instead.
- R10: If `chk_en` is 0 at the start strobe, neither `crc_ok` nor `crc_err` pulses for that packet, whatever the received checksum (for example 0000h).
- R11: A start strobe in any state restarts the checksum from FFFFh and abandons the packet in progress.
- R12: Cycles with `in_vld`=0 in the payload do not advance the checksum or the length count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sop | input | 1 | Start-of-payload strobe |
| mode_tx | input | 1 | Direction at start strobe: 1 transmit, 0 receive |
| chk_en | input | 1 | Receive checking enable, latched at start strobe |
| pay_len | input | 16 | Payload length in bytes, latched at start strobe |
| in_vld | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final payload byte |
| in_rdy | output | 1 | Low while checksum bytes are emitted |
| out_vld | output | 1 | Output byte valid (transmit only) |
| out_data | output | 8 | Output byte: payload, then checksum |
| crc_ok | output | 1 | One-cycle pass pulse |
| crc_err | output | 1 | One-cycle fail pulse |

## Verification
The assertions watch every cycle for the following:
- the reload to FFFFh after each start strobe;
- that the pass and fail pulses never coincide, last exactly one cycle, and arise only from the high-checksum state with checking latched on;
- that the emitted low checksum byte matches the register.

Only the directed scenarios can show the following:
- the actual checksum values, including the known vector and the empty payload;
- byte ordering on the output;
- that bytes offered during the hold-off are dropped;
- early termination by `in_last`, gaps, and an abandoned packet.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAYLOAD,
        ST_TX_LO,
        ST_TX_HI,
        ST_RX_LO,
        ST_RX_HI
    } crc_state_e;

    localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
    parameter int          DATA_W = 8,
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] chain [0:DATA_W];

    assign chain[0] = crc_i;

    // one reflected shift per data bit, bit 0 first
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        logic fb;
        assign fb = chain[g][0] ^ data_i[g];
        assign chain[g+1] = (chain[g] >> 1) ^ (fb ? POLY[CRC_W-1:0] : '0);
    end

    assign crc_o = chain[DATA_W];
endmodule

// File: rtl/paylen_counter.sv
module paylen_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             final_o
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign final_o = (cnt_q == {{(LEN_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/crc16_payload_engine.sv
module crc16_payload_engine
    import crc16_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sop,
    input  logic              mode_tx,
    input  logic              chk_en,
    input  logic [LEN_W-1:0]  pay_len,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_rdy,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data,
    output logic              crc_ok,
    output logic              crc_err
);
    localparam int CRC_W = 2 * DATA_W;

    crc_state_e       state_q, state_d;
    logic [CRC_W-1:0] crc_q, crc_nxt;
    logic [DATA_W-1:0] lo_q;
    logic             tx_q, chk_q;
    logic             acc, len_final, len_zero;

    assign len_zero = (pay_len == '0);
    assign acc      = in_vld && !sop && (state_q == ST_PAYLOAD);
    assign in_rdy   = !(state_q == ST_TX_LO || state_q == ST_TX_HI);

    crc16_byte_step #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY_REFL)
    ) u_step (
        .crc_i  (crc_q),
        .data_i (in_data),
        .crc_o  (crc_nxt)
    );

    paylen_counter #(
        .LEN_W (LEN_W)
    ) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sop),
        .load_val (pay_len),
        .dec      (acc),
        .final_o  (len_final)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_IDLE;
            ST_PAYLOAD: if (acc && (len_final || in_last))
                            state_d = tx_q ? ST_TX_LO : ST_RX_LO;
            ST_TX_LO:   state_d = ST_TX_HI;
            ST_TX_HI:   state_d = ST_IDLE;
            ST_RX_LO:   if (in_vld) state_d = ST_RX_HI;
            ST_RX_HI:   if (in_vld) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (sop) begin
            if (len_zero) state_d = mode_tx ? ST_TX_LO : ST_RX_LO;
            else          state_d = ST_PAYLOAD;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // checksum and capture datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET[CRC_W-1:0];
            lo_q  <= '0;
            tx_q  <= 1'b0;
            chk_q <= 1'b0;
        end else if (sop) begin
            crc_q <= CRC_PRESET[CRC_W-1:0];
            tx_q  <= mode_tx;
            chk_q <= chk_en;
        end else begin
            if (acc) crc_q <= crc_nxt;
            if (state_q == ST_RX_LO && in_vld) lo_q <= in_data;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
            crc_ok   <= 1'b0;
            crc_err  <= 1'b0;
        end else begin
            out_vld <= 1'b0;
            crc_ok  <= 1'b0;
            crc_err <= 1'b0;
            if (!sop) begin
                unique case (state_q)
                    ST_PAYLOAD: if (acc && tx_q) begin
                                    out_vld  <= 1'b1;
                                    out_data <= in_data;
                                end
                    ST_TX_LO:   begin
                                    out_vld  <= 1'b1;
                                    out_data <= crc_q[DATA_W-1:0];
                                end
                    ST_TX_HI:   begin
                                    out_vld  <= 1'b1;
                                    out_data <= crc_q[CRC_W-1:DATA_W];
                                end
                    ST_RX_HI:   if (in_vld && chk_q) begin
                                    crc_ok  <= ({in_data, lo_q} == crc_q);
                                    crc_err <= ({in_data, lo_q} != crc_q);
                                end
                    ST_IDLE, ST_RX_LO: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/crc16_payload_chk.sv
module crc16_payload_chk
    import crc16_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        sop,
    input logic        out_vld,
    input logic [7:0]  out_data,
    input logic        crc_ok,
    input logic        crc_err,
    input crc_state_e  state_q,
    input logic [15:0] crc_q,
    input logic        chk_q
);
    // R11
    preset_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sop |=> (crc_q == 16'hFFFF));

    // R8
    verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_ok && crc_err));

    // R8
    ok_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok || crc_err) |=> !(crc_ok || crc_err));

    // R9
    verdict_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok || crc_err) |-> ($past(state_q) == ST_RX_HI && $past(chk_q)));

    // R4
    tail_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX_LO && !sop) |=> (out_vld && out_data == $past(crc_q[7:0])));
endmodule

bind crc16_payload_engine crc16_payload_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sop      (sop),
    .out_vld  (out_vld),
    .out_data (out_data),
    .crc_ok   (crc_ok),
    .crc_err  (crc_err),
    .state_q  (state_q),
    .crc_q    (crc_q),
    .chk_q    (chk_q)
);

// File: tb/crc16_payload_engine_bench.sv
module crc16_payload_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sop = 1'b0, mode_tx = 1'b0, chk_en = 1'b0;
    logic [15:0] pay_len = '0;
    logic        in_vld = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_rdy, out_vld, crc_ok, crc_err;
    logic [7:0]  out_data;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] pl   [0:63];
    logic [7:0] obuf [0:127];
    int ocnt = 0, okc = 0, errc = 0;

    always #2 clk = ~clk;

    crc16_payload_engine u_crc16_payload_engine (
        .clk(clk), .rst_n(rst_n), .sop(sop), .mode_tx(mode_tx), .chk_en(chk_en),
        .pay_len(pay_len), .in_vld(in_vld), .in_data(in_data), .in_last(in_last),
        .in_rdy(in_rdy), .out_vld(out_vld), .out_data(out_data),
        .crc_ok(crc_ok), .crc_err(crc_err)
    );

    always @(posedge clk) begin
        #1;
        if (out_vld) begin
            if (ocnt < 128) obuf[ocnt] = out_data;
            ocnt++;
        end
        if (crc_ok)  okc++;
        if (crc_err) errc++;
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // MSB-first model on a bit-reversed register with polynomial 1021h
    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] r = 16'hFFFF;
        logic [15:0] o;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = r[15] ^ pl[i][b];
                r  = r << 1;
                if (fb) r = r ^ 16'h1021;
            end
        end
        for (int k = 0; k < 16; k++) o[k] = r[15-k];
        return o;
    endfunction

    task automatic start(input bit tx, input int len, input bit en);
        @(negedge clk);
        sop = 1; mode_tx = tx; pay_len = 16'(len); chk_en = en; in_vld = 0; in_last = 0;
        ocnt = 0; okc = 0; errc = 0;
        @(negedge clk);
        sop = 0;
    endtask

    task automatic feed(input int n, input int lastat, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                in_vld = 0; in_data = 8'h3C;
                @(negedge clk);
            end
            in_vld = 1; in_data = pl[i]; in_last = (i == lastat);
            @(negedge clk);
        end
        in_last = 0;
    endtask

    task automatic run_tx(input int n, input int len, input int lastat,
                          input bit gaps, input string req);
        logic [15:0] exp;
        start(1, len, 1);
        feed(n, lastat, gaps);
        in_vld = 1; in_data = 8'hA5;
        chk(in_rdy == 0, "R5", "in_rdy tail cycle 1", in_rdy, 0);
        @(negedge clk);
        chk(in_rdy == 0, "R5", "in_rdy tail cycle 2", in_rdy, 0);
        @(negedge clk);
        in_vld = 0;
        repeat (3) @(negedge clk);
        exp = ref_crc(n);
        chk(ocnt == n + 2, req, "output byte count", ocnt, n + 2);
        for (int i = 0; i < n && i < ocnt; i++)
            chk(obuf[i] == pl[i], "R3", "payload pass-through", obuf[i], pl[i]);
        if (ocnt == n + 2) begin
            chk(obuf[n] == exp[7:0], "R4", "low checksum byte", obuf[n], exp[7:0]);
            chk(obuf[n+1] == exp[15:8], "R4", "high checksum byte", obuf[n+1], exp[15:8]);
        end
    endtask

    task automatic run_rx(input int n, input logic [15:0] ck, input bit en,
                          input bit e_ok, input bit e_err, input string req);
        start(0, n, en);
        feed(n, -1, 0);
        in_vld = 1; in_data = ck[7:0];
        @(negedge clk);
        in_data = ck[15:8];
        @(negedge clk);
        in_vld = 0;
        chk(crc_ok == e_ok, req, "crc_ok after high byte", crc_ok, e_ok);
        chk(crc_err == e_err, req, "crc_err after high byte", crc_err, e_err);
        @(negedge clk);
        chk(!crc_ok && !crc_err, req, "pulse width one cycle", {crc_ok, crc_err}, 0);
        repeat (2) @(negedge clk);
        chk(okc == int'(e_ok) && errc == int'(e_err), req, "pulse count",
            okc * 16 + errc, int'(e_ok) * 16 + int'(e_err));
        chk(ocnt == 0, req, "no output in receive", ocnt, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] good;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(out_vld == 0 && crc_ok == 0 && crc_err == 0, "R1", "reset outputs",
            {out_vld, crc_ok, crc_err}, 0);
        chk(in_rdy == 1, "R1", "reset in_rdy", in_rdy, 1);

        // R2: known vector "123456789"
        for (int i = 0; i < 9; i++) pl[i] = 8'h31 + 8'(i);
        chk(ref_crc(9) == 16'h6F91, "R2", "model vector", ref_crc(9), 16'h6F91);
        run_tx(9, 9, -1, 0, "R2");
        chk(obuf[9] == 8'h91 && obuf[10] == 8'h6F, "R2", "vector checksum",
            {obuf[10], obuf[9]}, 16'h6F91);

        // R3 with a wider pattern
        for (int i = 0; i < 64; i++) pl[i] = 8'(i * 37 + 5);
        run_tx(16, 16, -1, 0, "R3");

        // R12: gaps between bytes
        run_tx(7, 7, -1, 1, "R12");

        // R7: in_last ends payload early
        run_tx(3, 10, 2, 0, "R7");

        // R6: empty payload
        run_tx(0, 0, -1, 0, "R6");
        chk(obuf[0] == 8'hFF && obuf[1] == 8'hFF, "R6", "empty checksum",
            {obuf[1], obuf[0]}, 16'hFFFF);

        // R11: abandon packet mid-way, then a full one
        start(1, 8, 1);
        feed(3, -1, 0);
        in_vld = 0;
        for (int i = 0; i < 64; i++) pl[i] = 8'(255 - i * 11);
        run_tx(5, 5, -1, 0, "R11");

        // R8 / R9 / R10 in receive direction
        for (int i = 0; i < 64; i++) pl[i] = 8'(i * 13 + 1);
        good = ref_crc(12);
        run_rx(12, good, 1, 1, 0, "R8");
        run_rx(12, good ^ 16'h0100, 1, 0, 1, "R9");
        run_rx(12, 16'h0000, 0, 0, 0, "R10");
        run_rx(12, good, 0, 0, 0, "R10");
        run_rx(0, 16'hFFFF, 1, 1, 0, "R6");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule